// File: doc/BRIEF.md
# Modbus RTU Frame Delimiter and CRC-16 Checker/Appender

This block sits between a UART receiver/transmitter and a command decoder on a serial field-bus link that uses the binary RTU framing. On the receive side it accepts one 8-bit character per arrival strobe. It decides where frames begin and end only by timing the silence between characters. It runs the reflected CRC-16 over each frame while the bytes arrive. When a frame closes it reports a one-cycle done strobe together with a good flag.

Received bytes are forwarded to the decoder two characters late, so the two trailing check bytes are never forwarded. A frame whose check fails, or that is too short to hold an address, a function code and a check, is reported as not good. The decoder then drops it without replying.

On the transmit side a helper forwards outgoing payload bytes one cycle late. It folds them into its own CRC and, on a close request, emits the check value low byte first and high byte last. Serialisation, parity and command decoding belong to neighbouring blocks.

Top module: `rtu_framer`

## Requirements
- R1: After reset all outputs are low, the line counts as already silent, and the first received strobe opens a new frame.
- R2: With HALF = CHAR_CYCLES/2, a frame closes when no receive strobe has been sampled for 7*HALF clock edges: frm_done rises exactly 7*HALF edges after the edge that sampled the last strobe, and it stays high for one cycle. A strobe sampled at that same edge or earlier continues the frame. A strobe one edge later starts a new frame.
- R3: The check register starts at 0xFFFF for each frame. Each byte is XORed into its low 8 bits and then shifted right eight times with zero fill, XORing 0xA001 after every shift that drops a 1. The register runs over every byte of the frame, the two check bytes included, and a valid frame leaves 0x0000 (example: payload 11 03 00 6B 00 03 has check bytes 76 then 87).
- R4: A frame whose residue is not zero closes with frm_good low.
- R5: A frame of fewer than 4 bytes closes with frm_good low, even if its residue is zero. A 4-byte frame with a zero residue closes with frm_good high.
- R6: Every received byte except the last two of its frame appears on pay_byte, in arrival order, with a one-cycle pay_stb. That byte is released in the cycle after the strobe that brings in the byte two positions later.
- R7: frm_good is low in every cycle where frm_done is low.
- R8: Each tx_stb byte appears on line_byte with line_stb one cycle later, in order. A tx_close produces, in the next two cycles, the check low byte and then the check high byte, computed with the R3 rule over the bytes sent since the previous close.
- R9: All transmit inputs are ignored in the cycle when the check high byte is being emitted: no extra output, and no effect on the check. Each transmit frame's check starts again from 0xFFFF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_stb | input | 1 | A received character is present this cycle |
| rx_byte | input | 8 | Received character |
| pay_stb | output | 1 | Payload byte valid |
| pay_byte | output | 8 | Payload byte (frame without its check bytes) |
| frm_done | output | 1 | One-cycle strobe: frame closed by silence |
| frm_good | output | 1 | With frm_done: residue zero and length at least 4 |
| tx_stb | input | 1 | Outgoing payload byte present this cycle |
| tx_byte | input | 8 | Outgoing payload byte |
| tx_close | input | 1 | Append the check to the bytes sent so far |
| line_stb | output | 1 | Outgoing line byte valid |
| line_byte | output | 8 | Outgoing line byte, check low byte before high byte |

## Verification
The bench builds the framer with CHAR_CYCLES = 8, so the silence threshold is 28 clock edges. At that size the exact closing edge, and the pair of gaps at 28 and 29 edges that either join or split a frame, can be reached in a few dozen cycles. Characters otherwise arrive every 8 cycles, which keeps every frame well inside the threshold. Even the longest table frame finishes in about a hundred cycles, so good, corrupted, minimum-length and too-short frames can all be run back to back.

// File: rtl/rtu_pkg.sv
package rtu_pkg;

    localparam logic [15:0] CRC_SEED = 16'hFFFF;
    localparam logic [15:0] CRC_POLY = 16'hA001;

    typedef logic [7:0] byte_t;

    // One byte through the reflected CRC-16: xor into the low byte, eight right shifts.
    function automatic logic [15:0] crc16_byte(input logic [15:0] crc_in, input byte_t b);
        logic [15:0] c;
        c = crc_in ^ {8'h00, b};
        for (int i = 0; i < 8; i++) begin
            if (c[0]) c = (c >> 1) ^ CRC_POLY;
            else      c = c >> 1;
        end
        return c;
    endfunction

endpackage

// File: rtl/rtu_crc16.sv
module rtu_crc16
    import rtu_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        init,
    input  logic        valid,
    input  byte_t       data,
    output logic [15:0] crc
);

    typedef struct packed {
        logic [15:0] crc;
    } crc_st_t;

    crc_st_t st_d, st_q;
    logic [15:0] base;

    always_comb begin
        base     = init ? CRC_SEED : st_q.crc;
        st_d.crc = valid ? crc16_byte(base, data) : base;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.crc <= CRC_SEED;
        else        st_q     <= st_d;
    end

    assign crc = st_q.crc;

endmodule

// File: rtl/rtu_gap_timer.sv
module rtu_gap_timer #(
    parameter int GAP_CYC = 7000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic strobe,
    output logic expire
);

    localparam int CW = $clog2(GAP_CYC + 1);

    typedef struct packed {
        logic [CW-1:0] idle;
    } gap_st_t;

    gap_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        expire = 1'b0;
        if (strobe) begin
            st_d.idle = '0;
        end else if (st_q.idle != CW'(GAP_CYC)) begin
            st_d.idle = st_q.idle + 1'b1;
            if (st_q.idle == CW'(GAP_CYC - 1)) expire = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q.idle <= CW'(GAP_CYC);
        else        st_q      <= st_d;
    end

    // A character restarts the silence count, so no expiry can follow it directly.
    assert_strobe_restarts_R2: assert property (@(posedge clk) disable iff (!rst_n)
        strobe |=> !expire);

endmodule

// File: rtl/rtu_tx_append.sv
module rtu_tx_append
    import rtu_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tx_stb,
    input  byte_t tx_byte,
    input  logic  tx_close,
    output logic  line_stb,
    output byte_t line_byte
);

    typedef struct packed {
        logic  hi;
        logic  stb;
        byte_t data;
    } tx_st_t;

    tx_st_t st_d, st_q;
    logic [15:0] crc;
    logic        crc_take;

    always_comb begin
        st_d     = st_q;
        st_d.stb = 1'b0;
        st_d.hi  = 1'b0;
        crc_take = 1'b0;
        if (st_q.hi) begin
            st_d.stb  = 1'b1;
            st_d.data = crc[15:8];
        end else if (tx_close) begin
            st_d.stb  = 1'b1;
            st_d.data = crc[7:0];
            st_d.hi   = 1'b1;
        end else if (tx_stb) begin
            st_d.stb  = 1'b1;
            st_d.data = tx_byte;
            crc_take  = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    rtu_crc16 u_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (st_q.hi),
        .valid (crc_take),
        .data  (tx_byte),
        .crc   (crc)
    );

    assign line_stb  = st_q.stb;
    assign line_byte = st_q.data;

    assert_close_low_first_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_close && !st_q.hi) |=> (line_stb && st_q.hi));

    assert_high_follows_R9: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.hi |=> (line_stb && !st_q.hi));

endmodule

// File: rtl/rtu_framer.sv
module rtu_framer
    import rtu_pkg::*;
#(
    parameter int CHAR_CYCLES = 2000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_stb,
    input  logic [7:0] rx_byte,
    output logic       pay_stb,
    output logic [7:0] pay_byte,
    output logic       frm_done,
    output logic       frm_good,
    input  logic       tx_stb,
    input  logic [7:0] tx_byte,
    input  logic       tx_close,
    output logic       line_stb,
    output logic [7:0] line_byte
);

    localparam int HALF_CYC  = CHAR_CYCLES / 2;
    localparam int GAP_CYC   = 7 * HALF_CYC;
    localparam int MIN_FRAME = 4;
    localparam int CNT_W     = $clog2(MIN_FRAME + 1);

    typedef struct packed {
        logic             in_frame;
        logic [CNT_W-1:0] cnt;
        byte_t            hold_old;
        byte_t            hold_new;
        logic             pay_stb;
        byte_t            pay_byte;
        logic             done;
        logic             good;
    } rx_st_t;

    rx_st_t      st_d, st_q;
    logic        gap_expire;
    logic        start;
    logic [15:0] rx_crc;

    rtu_gap_timer #(.GAP_CYC(GAP_CYC)) u_gap (
        .clk    (clk),
        .rst_n  (rst_n),
        .strobe (rx_stb),
        .expire (gap_expire)
    );

    assign start = rx_stb && !st_q.in_frame;

    rtu_crc16 u_rx_crc (
        .clk   (clk),
        .rst_n (rst_n),
        .init  (start),
        .valid (rx_stb),
        .data  (rx_byte),
        .crc   (rx_crc)
    );

    always_comb begin
        st_d         = st_q;
        st_d.pay_stb = 1'b0;
        st_d.done    = 1'b0;
        st_d.good    = 1'b0;
        if (rx_stb) begin
            st_d.in_frame = 1'b1;
            if (start) begin
                st_d.cnt      = CNT_W'(1);
                st_d.hold_new = rx_byte;
            end else begin
                if (st_q.cnt >= CNT_W'(2)) begin
                    st_d.pay_stb  = 1'b1;
                    st_d.pay_byte = st_q.hold_old;
                end
                st_d.hold_old = st_q.hold_new;
                st_d.hold_new = rx_byte;
                if (st_q.cnt != CNT_W'(MIN_FRAME)) st_d.cnt = st_q.cnt + 1'b1;
            end
        end else if (gap_expire && st_q.in_frame) begin
            st_d.in_frame = 1'b0;
            st_d.done     = 1'b1;
            st_d.good     = (rx_crc == 16'h0000) && (st_q.cnt >= CNT_W'(MIN_FRAME));
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign pay_stb  = st_q.pay_stb;
    assign pay_byte = st_q.pay_byte;
    assign frm_done = st_q.done;
    assign frm_good = st_q.good;

    rtu_tx_append u_tx (
        .clk       (clk),
        .rst_n     (rst_n),
        .tx_stb    (tx_stb),
        .tx_byte   (tx_byte),
        .tx_close  (tx_close),
        .line_stb  (line_stb),
        .line_byte (line_byte)
    );

    assert_done_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
        frm_done |=> !frm_done);

    assert_char_blocks_close_R2: assert property (@(posedge clk) disable iff (!rst_n)
        rx_stb |=> !frm_done);

    assert_good_needs_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !frm_done |-> !frm_good);

    assert_payload_after_char_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pay_stb |-> $past(rx_stb));

endmodule

// File: tb/rtu_framer_test.sv
`timescale 1ns/1ps
module rtu_framer_test;

    localparam int CHAR = 8;
    localparam int GAP  = 7 * (CHAR / 2);
    localparam int NV   = 6;

    localparam logic [7:0] VEC [NV][8] = '{
        '{8'h11, 8'h03, 8'h00, 8'h6B, 8'h00, 8'h03, 8'h00, 8'h00},
        '{8'h01, 8'h06, 8'h00, 8'h87, 8'h03, 8'h9E, 8'h00, 8'h00},
        '{8'hA5, 8'h5A, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'hFF, 8'h00, 8'hFF, 8'h00, 8'h12, 8'h34, 8'h56, 8'h78},
        '{8'h7E, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00, 8'h00},
        '{8'h11, 8'h10, 8'h00, 8'h87, 8'h00, 8'h02, 8'h04, 8'h00}
    };
    localparam int VLEN [NV] = '{6, 6, 2, 8, 1, 8};
    localparam bit VBAD [NV] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1};

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_stb = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_stb = 1'b0;
    logic [7:0] tx_byte = 8'h00;
    logic       tx_close = 1'b0;
    logic       pay_stb, frm_done, frm_good, line_stb;
    logic [7:0] pay_byte, line_byte;

    int tests = 0;
    int fails = 0;
    logic [7:0] pbuf [512];
    logic [7:0] tbuf [512];
    bit         okv  [64];
    int pcnt = 0, tcnt = 0, ecnt = 0;

    always #2.5 clk = ~clk;

    rtu_framer #(.CHAR_CYCLES(CHAR)) uut (
        .clk(clk), .rst_n(rst_n),
        .rx_stb(rx_stb), .rx_byte(rx_byte),
        .pay_stb(pay_stb), .pay_byte(pay_byte),
        .frm_done(frm_done), .frm_good(frm_good),
        .tx_stb(tx_stb), .tx_byte(tx_byte), .tx_close(tx_close),
        .line_stb(line_stb), .line_byte(line_byte)
    );

    always @(negedge clk) begin
        if (rst_n) begin
            if (pay_stb)  begin pbuf[pcnt % 512] = pay_byte;  pcnt++; end
            if (line_stb) begin tbuf[tcnt % 512] = line_byte; tcnt++; end
            if (frm_done) begin okv[ecnt % 64] = frm_good; ecnt++; end
        end
    end

    function automatic logic [15:0] ref_crc(input logic [15:0] c_in, input logic [7:0] b);
        logic [15:0] c;
        logic        fb;
        c = c_in;
        for (int i = 0; i < 8; i++) begin
            fb = c[0] ^ b[i];
            c  = c >> 1;
            if (fb) c = c ^ 16'hA001;
        end
        return c;
    endfunction

    task automatic chk(input bit cond, input string req, input int act, input int exp);
        tests++;
        if (!cond) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Strobe sampled d edges after the previous strobe's sampling edge (d >= 2).
    task automatic send_after(input int d, input logic [7:0] b);
        repeat (d - 2) @(negedge clk);
        @(negedge clk);
        rx_stb  = 1'b1;
        rx_byte = b;
        @(negedge clk);
        rx_stb  = 1'b0;
    endtask

    task automatic tx_frame(input int r);
        for (int i = 0; i < VLEN[r]; i++) begin
            @(negedge clk);
            tx_stb  = 1'b1;
            tx_byte = VEC[r][i];
        end
        @(negedge clk);
        tx_stb   = 1'b0;
        tx_close = 1'b1;
        @(negedge clk);
        tx_close = 1'b0;
        tx_stb   = 1'b1;
        tx_byte  = 8'hEE;
        @(negedge clk);
        tx_stb   = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        #(5.0 * 150000);
        tests++;
        fails++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [15:0] c;
        logic [7:0]  lo;
        int pb, eb, tb, miss;
        bit exp_ok;

        // reset state (R1)
        repeat (4) @(negedge clk);
        chk(!pay_stb && !frm_done && !frm_good && !line_stb, "R1 outputs low in reset",
            {pay_stb, frm_done, frm_good, line_stb}, 0);
        rst_n = 1'b1;
        idle(2);
        chk(!pay_stb && !frm_done && !frm_good && !line_stb, "R1 outputs low after reset",
            {pay_stb, frm_done, frm_good, line_stb}, 0);

        // table walk: receive and transmit each vector
        for (int r = 0; r < NV; r++) begin
            c = 16'hFFFF;
            for (int i = 0; i < VLEN[r]; i++) c = ref_crc(c, VEC[r][i]);
            lo = c[7:0] ^ (VBAD[r] ? 8'h01 : 8'h00);
            exp_ok = !VBAD[r] && (VLEN[r] + 2 >= 4);
            pb = pcnt;
            eb = ecnt;
            for (int i = 0; i < VLEN[r]; i++) send_after(CHAR, VEC[r][i]);
            send_after(CHAR, lo);
            send_after(CHAR, c[15:8]);
            idle(GAP + 4);
            chk(ecnt == eb + 1, "R2 one close per frame", ecnt - eb, 1);
            chk(okv[eb % 64] == exp_ok,
                VBAD[r] ? "R4 bad check flagged" : (exp_ok ? "R3 good frame" : "R5 short frame dropped"),
                okv[eb % 64], exp_ok);
            chk(pcnt - pb == VLEN[r], "R6 payload count", pcnt - pb, VLEN[r]);
            miss = 0;
            for (int i = 0; i < VLEN[r]; i++) if (pbuf[(pb + i) % 512] != VEC[r][i]) miss++;
            chk(miss == 0, "R6 payload bytes in order", miss, 0);

            tb = tcnt;
            tx_frame(r);
            idle(4);
            chk(tcnt - tb == VLEN[r] + 2, "R9 high slot input ignored", tcnt - tb, VLEN[r] + 2);
            miss = 0;
            for (int i = 0; i < VLEN[r]; i++) if (tbuf[(tb + i) % 512] != VEC[r][i]) miss++;
            chk(miss == 0, "R8 tx bytes pass in order", miss, 0);
            chk({tbuf[(tb + VLEN[r] + 1) % 512], tbuf[(tb + VLEN[r]) % 512]} == c,
                "R8 check low then high", {tbuf[(tb + VLEN[r] + 1) % 512], tbuf[(tb + VLEN[r]) % 512]}, c);
            if (r == 0)
                chk(tbuf[(tb + 6) % 512] == 8'h76 && tbuf[(tb + 7) % 512] == 8'h87,
                    "R3 known check 76 87", {tbuf[(tb + 6) % 512], tbuf[(tb + 7) % 512]}, 16'h7687);
        end

        // seed restarts for each transmit frame (R9)
        tb = tcnt;
        tx_frame(0);
        idle(4);
        chk(tbuf[(tb + 6) % 512] == 8'h76 && tbuf[(tb + 7) % 512] == 8'h87,
            "R9 seed restarts", {tbuf[(tb + 6) % 512], tbuf[(tb + 7) % 512]}, 16'h7687);

        // gap of exactly the threshold joins the frame (R2)
        c = ref_crc(ref_crc(16'hFFFF, 8'hA5), 8'h5A);
        eb = ecnt;
        send_after(CHAR, 8'hA5);
        send_after(GAP, 8'h5A);
        send_after(CHAR, c[7:0]);
        send_after(CHAR, c[15:8]);
        idle(GAP + 4);
        chk(ecnt == eb + 1, "R2 gap at threshold joins", ecnt - eb, 1);
        chk(okv[eb % 64] == 1'b1, "R2 joined frame good", okv[eb % 64], 1);

        // gap one edge longer splits (R2), 4-byte frame good (R5)
        c = ref_crc(ref_crc(16'hFFFF, 8'h02), 8'h03);
        eb = ecnt;
        pb = pcnt;
        send_after(CHAR, 8'h01);
        send_after(GAP + 1, 8'h02);
        send_after(CHAR, 8'h03);
        send_after(CHAR, c[7:0]);
        send_after(CHAR, c[15:8]);
        idle(GAP + 4);
        chk(ecnt == eb + 2, "R2 gap past threshold splits", ecnt - eb, 2);
        chk(okv[eb % 64] == 1'b0, "R5 single byte frame dropped", okv[eb % 64], 0);
        chk(okv[(eb + 1) % 64] == 1'b1, "R5 four byte frame good", okv[(eb + 1) % 64], 1);
        chk(pcnt - pb == 2 && pbuf[pb % 512] == 8'h02, "R6 split frame payload", pcnt - pb, 2);

        // exact close edge (R2) and good flag confined to it (R7)
        c = ref_crc(ref_crc(16'hFFFF, 8'hA5), 8'h5A);
        send_after(CHAR, 8'hA5);
        send_after(CHAR, 8'h5A);
        send_after(CHAR, c[7:0]);
        send_after(CHAR, c[15:8]);
        idle(GAP - 1);
        chk(!frm_done, "R2 no close one edge early", frm_done, 0);
        chk(!frm_good, "R7 good low before close", frm_good, 0);
        idle(1);
        chk(frm_done, "R2 close at threshold edge", frm_done, 1);
        chk(frm_good, "R3 close reports good", frm_good, 1);
        idle(1);
        chk(!frm_done && !frm_good, "R7 close is one cycle", {frm_done, frm_good}, 0);

        finish_run();
    end

endmodule